// File: doc/BRIEF.md
# Dual-Clock Simple Dual-Port RAM

A 4096-bit memory with one write port and one read port, each running on its own clock. The write side captures the data word, address, lane enables and write strobe on its clock. The stored word changes on the next enabled write edge. The read side captures the address and read strobe on its clock. One enabled edge later, it loads the addressed word into a registered output.

A parameter picks one of five width/depth pairings, and the total storage stays at 4096 bits. Each side has its own clock enable and its own active-low asynchronous clear. The read-strobe register is deliberately left out of the read-side clear.

Top module: `dc_sdp_ram`

## Requirements
- R1: `DATA_W` is one of 1, 2, 4, 8 or 16. The depth is 4096/`DATA_W` words, and the address width is log2 of that depth.
- R2: On a `wr_clk` edge with `wr_ce` high, the write inputs are captured. On the next `wr_clk` edge with `wr_ce` high, if the captured strobe is 1, the captured word is written to the captured address.
- R3: While `wr_ce` is low, the write-side registers hold. A write strobe presented only while `wr_ce` is low writes nothing.
- R4: On a `rd_clk` edge with `rd_ce` high, `rd_addr` and `rd_en` are captured. On the next such edge, if the captured strobe is 1, `rd_data` takes the word stored at the captured address. After the first edge alone, `rd_data` still shows its old value.
- R5: While `rd_ce` is low, `rd_data` and the read-side registers hold.
- R6: When the captured read strobe is 0, `rd_data` holds its value on enabled edges.
- R7: Driving `rd_clr_n` low sets `rd_data` and the captured read address to zero at once, without waiting for a clock edge.
- R8: `rd_clr_n` does not clear the captured read strobe. A strobe captured before a clear still loads `rd_data`, from address 0, on the first enabled edge after the clear.
- R9: Driving `wr_clr_n` low clears the captured write inputs at once, so a write that is captured but not yet committed is cancelled.
- R10: Bit 0 of `wr_be` enables data bits 7:0 and bit 1 enables bits 15:8 in the 16-bit shape. In the 8-bit shape, one bit enables the whole word. In the narrower shapes, `wr_be` (1 bit) is ignored and the whole word is written.
- R11: A read that does not overlap a write to the same address returns the most recent value written there, as merged by R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_clr_n | input | 1 | Write-side asynchronous clear, active low |
| wr_ce | input | 1 | Write clock enable |
| wr_data | input | DATA_W | Word to write |
| wr_addr | input | ADDR_W | Write address |
| wr_en | input | 1 | Write strobe |
| wr_be | input | BE_W | Byte-lane enables (2 bits for x16, 1 bit otherwise) |
| rd_clk | input | 1 | Read clock |
| rd_clr_n | input | 1 | Read-side asynchronous clear, active low |
| rd_ce | input | 1 | Read clock enable |
| rd_addr | input | ADDR_W | Read address |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered read data |

## Verification
The assertions assume that every input of a side changes only away from that side's active clock edge. They also assume that each clear is held low across at least one edge of its own clock, so the edge after a clear never sees a register that was cleared and released between two samples. The stimulus drives both sides on the falling edges of their own clocks, and it stretches every clear pulse over a rising edge. It never reads an address while a write to that address is still pending in the other clock domain, so every read it checks has one defined value.

// File: rtl/sdp_pkg.sv
`timescale 1ns/1ps
// Shared constants and the lane-mask helper for the dual-clock RAM.
// Assumes the widest word is 16 bits, i.e. at most two 8-bit lanes.
package sdp_pkg;
    localparam int ARRAY_BITS = 4096;
    localparam int LANE_BITS  = 8;
    localparam int MAX_W      = 16;

    // Bit mask of the word bits a write may change, given the lane enables.
    function automatic logic [MAX_W-1:0] lane_mask(input int width, input logic [1:0] be);
        logic [MAX_W-1:0] m;
        if (width < LANE_BITS) begin
            m = '1;
        end else begin
            m = '0;
            for (int l = 0; l < 2; l++) begin
                if (be[l] && (l * LANE_BITS < width)) begin
                    m[l*LANE_BITS +: LANE_BITS] = '1;
                end
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/sdp_wr_side.sv
`timescale 1ns/1ps
// Write-side input registers: capture word, address, lane enables and strobe.
// Assumes inputs are stable around wr_clk rising edges; wr_clr_n is asynchronous.
module sdp_wr_side #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8,
    parameter int BE_W   = 2
) (
    input  logic              wr_clk,
    input  logic              wr_clr_n,
    input  logic              wr_ce,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wen,
    input  logic [BE_W-1:0]   wbe,
    output logic [DATA_W-1:0] data_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              we_q,
    output logic [BE_W-1:0]   be_q
);
    // Capture the write request when the write clock is enabled.
    always_ff @(posedge wr_clk or negedge wr_clr_n) begin
        if (!wr_clr_n) begin
            data_q <= '0;
            addr_q <= '0;
            we_q   <= 1'b0;
            be_q   <= '0;
        end else if (wr_ce) begin
            data_q <= wdata;
            addr_q <= waddr;
            we_q   <= wen;
            be_q   <= wbe;
        end
    end

    // R3: a disabled write clock leaves every captured value untouched.
    a_r3_wr_hold: assert property (@(posedge wr_clk) disable iff (!wr_clr_n)
        (wr_clr_n && !wr_ce) |=> ($stable(data_q) && $stable(addr_q) && $stable(we_q) && $stable(be_q)));
endmodule

// File: rtl/sdp_mem_array.sv
`timescale 1ns/1ps
// Storage array: lane-masked write on wr_clk, asynchronous read of one word.
// Assumes the read address comes from a register in the read clock domain.
module sdp_mem_array
    import sdp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8,
    parameter int BE_W   = 2
) (
    input  logic              wr_clk,
    input  logic              wr_clr_n,
    input  logic              wr_ce,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BE_W-1:0]   wbe,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [MAX_W-1:0]  mask_full;
    logic [DATA_W-1:0] mask;

    // Expand the lane enables into a per-bit write mask for this shape.
    always_comb begin
        mask_full = lane_mask(DATA_W, 2'(wbe));
        mask      = mask_full[DATA_W-1:0];
    end

    // Commit the captured write, merging only the enabled lanes.
    always_ff @(posedge wr_clk) begin
        if (wr_ce && we) begin
            mem[waddr] <= (mem[waddr] & ~mask) | (wdata & mask);
        end
    end

    // Present the word at the registered read address.
    assign rdata = mem[raddr];

    // R9: while the write side is cleared no strobe reaches the array.
    a_r9_clr_blocks_write: assert property (@(posedge wr_clk) !wr_clr_n |-> !we);
endmodule

// File: rtl/sdp_rd_side.sv
`timescale 1ns/1ps
// Read-side registers: address and strobe capture, plus the data output register.
// Assumes inputs are stable around rd_clk rising edges; the strobe register has no clear.
module sdp_rd_side #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              rd_clk,
    input  logic              rd_clr_n,
    input  logic              rd_ce,
    input  logic [ADDR_W-1:0] raddr,
    input  logic              ren,
    input  logic [DATA_W-1:0] rword,
    output logic [ADDR_W-1:0] raddr_q,
    output logic [DATA_W-1:0] dout
);
    logic ren_q;

    // Capture the read address when the read clock is enabled.
    always_ff @(posedge rd_clk or negedge rd_clr_n) begin
        if (!rd_clr_n)  raddr_q <= '0;
        else if (rd_ce) raddr_q <= raddr;
    end

    // Capture the read strobe; this register is outside the clear.
    always_ff @(posedge rd_clk) begin
        if (rd_ce) ren_q <= ren;
    end

    // Load the output word when a captured strobe is pending.
    always_ff @(posedge rd_clk or negedge rd_clr_n) begin
        if (!rd_clr_n)           dout <= '0;
        else if (rd_ce && ren_q) dout <= rword;
    end

    // R4: an enabled edge with a captured strobe loads the array word.
    a_r4_load: assert property (@(posedge rd_clk) disable iff (!rd_clr_n)
        (rd_clr_n && rd_ce && ren_q) |=> (dout == $past(rword)));
    // R5: a disabled read clock freezes the output.
    a_r5_rd_hold: assert property (@(posedge rd_clk) disable iff (!rd_clr_n)
        (rd_clr_n && !rd_ce) |=> $stable(dout));
    // R6: without a captured strobe the output is kept.
    a_r6_no_strobe_hold: assert property (@(posedge rd_clk) disable iff (!rd_clr_n)
        (rd_clr_n && rd_ce && !ren_q) |=> $stable(dout));
    // R7: the clear forces output and address register to zero.
    a_r7_clear_zero: assert property (@(posedge rd_clk)
        !rd_clr_n |-> (dout == '0 && raddr_q == '0));
endmodule

// File: rtl/dc_sdp_ram.sv
`timescale 1ns/1ps
// Dual-clock simple dual-port RAM over a fixed 4096-bit array.
// Assumes DATA_W is 1, 2, 4, 8 or 16 and that same-address accesses
// from the two clocks are not overlapped by the user.
module dc_sdp_ram
    import sdp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = $clog2(ARRAY_BITS / DATA_W),
    parameter int BE_W   = (DATA_W >= MAX_W) ? 2 : 1
) (
    input  logic              wr_clk,
    input  logic              wr_clr_n,
    input  logic              wr_ce,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_en,
    input  logic [BE_W-1:0]   wr_be,
    input  logic              rd_clk,
    input  logic              rd_clr_n,
    input  logic              rd_ce,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = ARRAY_BITS / DATA_W;

    logic [DATA_W-1:0] wdata_q;
    logic [ADDR_W-1:0] waddr_q;
    logic              we_q;
    logic [BE_W-1:0]   wbe_q;
    logic [ADDR_W-1:0] raddr_q;
    logic [DATA_W-1:0] rword;

    // R1: only the five supported shapes, with matching address and lane widths.
    initial begin
        a_r1_shape: assert ((DATA_W == 1 || DATA_W == 2 || DATA_W == 4 || DATA_W == 8 || DATA_W == 16)
                            && (1 << ADDR_W) == DEPTH
                            && BE_W == ((DATA_W >= MAX_W) ? 2 : 1))
            else $error("dc_sdp_ram: unsupported shape DATA_W=%0d", DATA_W);
    end

    sdp_wr_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BE_W(BE_W)) u_wr (
        .wr_clk  (wr_clk),
        .wr_clr_n(wr_clr_n),
        .wr_ce   (wr_ce),
        .wdata   (wr_data),
        .waddr   (wr_addr),
        .wen     (wr_en),
        .wbe     (wr_be),
        .data_q  (wdata_q),
        .addr_q  (waddr_q),
        .we_q    (we_q),
        .be_q    (wbe_q)
    );

    sdp_mem_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .BE_W(BE_W)) u_mem (
        .wr_clk  (wr_clk),
        .wr_clr_n(wr_clr_n),
        .wr_ce   (wr_ce),
        .we      (we_q),
        .waddr   (waddr_q),
        .wdata   (wdata_q),
        .wbe     (wbe_q),
        .raddr   (raddr_q),
        .rdata   (rword)
    );

    sdp_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .rd_clk  (rd_clk),
        .rd_clr_n(rd_clr_n),
        .rd_ce   (rd_ce),
        .raddr   (rd_addr),
        .ren     (rd_en),
        .rword   (rword),
        .raddr_q (raddr_q),
        .dout    (rd_data)
    );
endmodule

// File: tb/tb_dc_sdp_ram.sv
`timescale 1ns/1ps
// Bench: one instance per shape, write clock 200 MHz, read clock unrelated.
module tb_dc_sdp_ram;
    logic wclk = 1'b0;
    logic rclk = 1'b0;
    always #2.5  wclk = ~wclk;
    always #3.65 rclk = ~rclk;

    int  n_checks = 0;
    int  n_err    = 0;
    bit  done [5];

    for (genvar gi = 0; gi < 5; gi++) begin : g_shape
        localparam int W     = 1 << gi;
        localparam int DEPTH = 4096 / W;
        localparam int AW    = $clog2(DEPTH);
        localparam int BW    = (W >= 16) ? 2 : 1;

        logic          wclr_n = 1'b0, wce = 1'b1, wen = 1'b0;
        logic [W-1:0]  wdata  = '0;
        logic [AW-1:0] waddr  = '0;
        logic [BW-1:0] wbe    = '0;
        logic          rclr_n = 1'b0, rce = 1'b1, ren = 1'b0;
        logic [AW-1:0] raddr  = '0;
        logic [W-1:0]  dout;
        logic [W-1:0]  ref_mem [DEPTH];

        dc_sdp_ram #(.DATA_W(W)) dut (
            .wr_clk(wclk), .wr_clr_n(wclr_n), .wr_ce(wce), .wr_data(wdata),
            .wr_addr(waddr), .wr_en(wen), .wr_be(wbe),
            .rd_clk(rclk), .rd_clr_n(rclr_n), .rd_ce(rce), .rd_addr(raddr),
            .rd_en(ren), .rd_data(dout)
        );

        function automatic logic [AW-1:0] pool(input int k);
            return (k == 15) ? AW'(DEPTH - 1) : AW'((k * 37) % DEPTH);
        endfunction

        // Expected stored word after a write, from R10.
        function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] d,
                                               input logic [BW-1:0] b);
            logic [15:0] r  = 16'(old);
            logic [15:0] n  = 16'(d);
            logic [1:0]  bb = 2'(b);
            if (W < 8) return d;
            for (int l = 0; l < 2; l++) begin
                if (bb[l] && l * 8 < W) r[l*8 +: 8] = n[l*8 +: 8];
            end
            return W'(r);
        endfunction

        task automatic chk(input string tag, input string what, input logic [15:0] act,
                           input logic [15:0] exp);
            n_checks++;
            if (act !== exp) begin
                n_err++;
                $display("FAIL %s x%0d %s: actual %h expected %h", tag, W, what, act, exp);
            end
        endtask

        task automatic do_write(input logic [AW-1:0] a, input logic [W-1:0] d, input logic [BW-1:0] b);
            @(negedge wclk); waddr = a; wdata = d; wbe = b; wen = 1'b1;
            @(negedge wclk); wen = 1'b0;
            @(negedge wclk);
            ref_mem[a] = merge(ref_mem[a], d, b);
        endtask

        task automatic do_read(input logic [AW-1:0] a, output logic [W-1:0] q);
            @(negedge rclk); raddr = a; ren = 1'b1;
            @(negedge rclk);
            @(negedge rclk); q = dout; ren = 1'b0;
        endtask

        initial begin
            logic [W-1:0] q;
            logic [AW-1:0] a;
            logic [AW-1:0] p1 = pool(1);
            logic [AW-1:0] p2 = pool(2);
            void'($urandom(32'd11 + gi));
            repeat (4) @(negedge wclk);
            repeat (2) @(negedge rclk);
            chk("R7", "output during reset", 16'(dout), 16'h0);
            wclr_n = 1'b1;
            @(negedge rclk); rclr_n = 1'b1;

            // Fill the address pool with full-word writes (R2, R11).
            for (int k = 0; k < 16; k++) do_write(pool(k), W'($urandom), '1);
            do_write('0, '1, '1);
            do_write(p1, '0, '1);
            do_read(DEPTH - 1, q);
            chk("R2", "top address", 16'(q), 16'(ref_mem[DEPTH-1]));

            // Random writes, some lane-limited, each read back (R10, R11).
            for (int i = 0; i < 40; i++) begin
                a = pool(2 + int'($urandom_range(0, 13)));
                do_write(a, W'($urandom), BW'($urandom));
                do_read(a, q);
                chk("R11", "random readback", 16'(q), 16'(ref_mem[a]));
            end

            // R10: directed lane cases.
            do_write(p2, ~ref_mem[p2], '0);
            do_read(p2, q);
            chk("R10", "zero lane enables", 16'(q), 16'(ref_mem[p2]));
            do_write(p2, ~ref_mem[p2], BW'(1));
            do_read(p2, q);
            chk("R10", "low lane only", 16'(q), 16'(ref_mem[p2]));

            // R3: strobe offered only while the write clock is disabled.
            @(negedge wclk); wce = 1'b0; waddr = p2; wdata = ~ref_mem[p2]; wbe = '1; wen = 1'b1;
            repeat (3) @(negedge wclk);
            wen = 1'b0;
            @(negedge wclk); wce = 1'b1;
            repeat (2) @(negedge wclk);
            do_read(p2, q);
            chk("R3", "write with clock enable low", 16'(q), 16'(ref_mem[p2]));

            // R4: latency, address 0 holds ones, p1 holds zero.
            do_read('0, q);
            chk("R4", "load all-ones word", 16'(q), 16'(ref_mem[0]));
            @(negedge rclk); raddr = p1; ren = 1'b1;
            @(negedge rclk);
            chk("R4", "after first edge", 16'(dout), 16'(ref_mem[0]));
            @(negedge rclk);
            chk("R4", "after second edge", 16'(dout), 16'(ref_mem[p1]));

            // R6: captured strobe low keeps the output.
            ren = 1'b0; raddr = '0;
            repeat (3) @(negedge rclk);
            chk("R6", "strobe low hold", 16'(dout), 16'(ref_mem[p1]));

            // R5: read clock disabled keeps the output.
            rce = 1'b0; ren = 1'b1;
            repeat (3) @(negedge rclk);
            chk("R5", "clock enable low hold", 16'(dout), 16'(ref_mem[p1]));
            rce = 1'b1;
            repeat (2) @(negedge rclk);
            chk("R4", "load after re-enable", 16'(dout), 16'(ref_mem[0]));

            // R7: asynchronous clear of the output.
            rclr_n = 1'b0;
            #1;
            chk("R7", "immediate clear", 16'(dout), 16'h0);
            @(negedge rclk); rclr_n = 1'b1;

            // R8: strobe captured before a clear survives it and loads from address 0.
            @(negedge rclk); raddr = p1; ren = 1'b1;
            @(negedge rclk); rce = 1'b0; ren = 1'b0; rclr_n = 1'b0;
            @(negedge rclk); rclr_n = 1'b1; rce = 1'b1;
            @(negedge rclk);
            chk("R8", "strobe survives clear", 16'(dout), 16'(ref_mem[0]));

            // R9: clearing the write side cancels a captured write.
            @(negedge wclk); waddr = p1; wdata = '1; wbe = '1; wen = 1'b1;
            @(negedge wclk); wen = 1'b0; wclr_n = 1'b0;
            @(negedge wclk); wclr_n = 1'b1;
            repeat (2) @(negedge wclk);
            do_read(p1, q);
            chk("R9", "cancelled write", 16'(q), 16'(ref_mem[p1]));
            done[gi] = 1'b1;
        end
    end

    initial begin
        wait (done[0] && done[1] && done[2] && done[3] && done[4]);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #1000000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule